// File: doc/BRIEF.md
# ADC Channel-Queue Conversion Sequencer

This block sits between a register-side host and an analog-to-digital converter core. The host writes channel numbers into a small channel queue. Once the queue holds a programmed number of entries, the block issues one start request per entry and waits for the converter's done strobe after each one. It stores every returned sample in a result queue. It also folds the per-conversion compare-hit bits into one verdict, and it raises a completion flag when the whole set has been converted and enough results are waiting.

A 3-bit set-size code chooses the queue level. The value 0 gives single-shot operation, where one channel write starts one conversion at once. A set can start in either of two ways: as soon as the queue fills, or on a hardware trigger. The hardware trigger can be blocked by a manual mask bit, or blocked automatically while unread results remain. In continuous mode, the block restarts the same set in the cycle the completion flag rises. When scan is off, every conversion in the set uses the first queued channel.

Top module: `adc_seq_top`

## Requirements
- R1: The set size is N = code + 1 for `cfg_depth` codes 1 to 7. Code 0 gives N = 1, so a single channel write starts one conversion without queuing. Each set issues exactly N `conv_start` pulses, and each pulse waits for a `conv_done`.
- R2: No conversion of a set starts while the channel queue holds fewer than N entries.
- R3: `coco` rises after the N-th `conv_done` of a set, provided the compare verdict is true and the result queue holds at least N entries.
- R4: With `cmp_all` = 0, the verdict is the OR of the set's `conv_hit` bits, so a single hit is enough.
- R5: With `cmp_all` = 1, the verdict is the AND of the set's `conv_hit` bits, so a single miss suppresses `coco`.
- R6: With `scan_en` = 1, conversion k of a set uses queue entry k, oldest first. With `scan_en` = 0, every conversion of the set uses the oldest entry.
- R7: With `trig_sel_hw` = 1 and `trig_mask_auto` = 0, the level of `trig_mask` alone decides this: 1 blocks `hw_trig` from starting a set, and 0 lets it start one.
- R8: With `trig_sel_hw` = 1 and `trig_mask_auto` = 1, `hw_trig` is ignored while `res_valid` is 1 and accepted once the result queue is empty.
- R9: With `cont_en` = 1, `conv_start` is high in the same cycle that `coco` rises, and the new set repeats the same channel order.
- R10: `res_data` shows the oldest unread result while `res_valid` is 1. A `res_rd` pulse pops it, and `coco` clears once the result queue is empty.
- R11: A `cfg_depth_wr` pulse empties both queues, abandons any set in progress and clears `coco`.
- R12: A channel write is ignored when the channel queue already holds N entries. After a software-started set completes with `cont_en` = 0, the channel queue is emptied. In hardware-trigger mode it is kept for the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth_wr | input | 1 | Strobe that loads `cfg_depth` and flushes the sequencer |
| cfg_depth | input | 3 | Set-size code |
| cmp_all | input | 1 | 1: AND the compare hits; 0: OR them |
| scan_en | input | 1 | 1: walk the queued channels; 0: repeat the first one |
| cont_en | input | 1 | Restart the set on completion |
| trig_sel_hw | input | 1 | 1: sets start on `hw_trig`; 0: they start when the queue fills |
| trig_mask | input | 1 | Manual hardware-trigger block |
| trig_mask_auto | input | 1 | Block the hardware trigger while results are unread |
| hw_trig | input | 1 | Hardware trigger pulse |
| ch_wr | input | 1 | Channel write strobe |
| ch_wdata | input | CH_W | Channel number to queue |
| conv_start | output | 1 | Start request to the converter |
| conv_chan | output | CH_W | Channel for the current request |
| conv_done | input | 1 | Converter finished |
| conv_result | input | RES_W | Converted sample |
| conv_hit | input | 1 | Compare outcome of this conversion |
| res_rd | input | 1 | Pop the oldest result |
| res_data | output | RES_W | Oldest unread result |
| res_valid | output | 1 | Result queue not empty |
| coco | output | 1 | Conversion-set-complete flag |

## Verification
If the set counter or queue pointers go wrong, the converter sees an extra or missing `conv_start`, or a wrong `conv_chan`, within a few cycles of the N-th channel write. A wrong hit accumulator shows at `coco` one cycle after the last `conv_done`. A corrupted result pointer shows at `res_data` on the next read. A stale mask decision, or a flush that leaves state behind, shows as a start that should not happen, or a missing one, within a few cycles of the trigger or the channel write that follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_DEPTH = 1 << CODE_W;
  localparam int unsigned CNT_W     = $clog2(MAX_DEPTH + 1);
  localparam int unsigned IDX_W     = $clog2(MAX_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_FIN} seq_state_t;

  // set size from the code: 0 means one conversion, otherwise code + 1
  function automatic logic [CNT_W-1:0] set_size(input logic [CODE_W-1:0] code);
    return (code == '0) ? CNT_W'(1) : CNT_W'(code) + CNT_W'(1);
  endfunction

  // neutral start value of the compare accumulator
  function automatic logic hit_seed(input logic and_mode);
    return and_mode;
  endfunction

  function automatic logic hit_fold(input logic and_mode, input logic acc, input logic hit);
    return and_mode ? (acc & hit) : (acc | hit);
  endfunction
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int unsigned W = 8,
  parameter int unsigned D = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  input  logic [$clog2(D)-1:0]       idx,
  output logic [W-1:0]               dout,
  output logic [$clog2(D+1)-1:0]     count
);
  localparam int unsigned AW = $clog2(D);
  localparam int unsigned CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   sum, wrap;
  logic [AW-1:0] rd_addr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(D - 1)) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push && (count != CW'(D));
  assign do_pop  = pop && (count != '0);

  assign sum     = {1'b0, rp} + {1'b0, idx};
  assign wrap    = sum - (AW+1)'(D);
  assign rd_addr = (sum >= (AW+1)'(D)) ? wrap[AW-1:0] : sum[AW-1:0];
  assign dout    = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(D));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cmp_all,
  input  logic              scan_en,
  input  logic              cont_en,
  input  logic              trig_sel_hw,
  input  logic              trig_mask,
  input  logic              trig_mask_auto,
  input  logic              hw_trig,
  input  logic [CNT_W-1:0]  chan_count,
  input  logic [CNT_W-1:0]  res_count,
  input  logic              conv_done,
  input  logic              conv_hit,
  output logic              conv_start,
  output logic [IDX_W-1:0]  chan_idx,
  output logic              res_push,
  output logic              chan_flush,
  output logic              coco,
  output logic [CNT_W-1:0]  set_n
);
  seq_state_t        state;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  k;
  logic              acc;

  // named internal events
  logic hw_blocked, armed, set_go, last_conv, fin_evt, coco_set;

  assign set_n      = set_size(code_q);
  assign hw_blocked = trig_mask_auto ? (res_count != '0) : trig_mask;
  assign armed      = (state == S_IDLE) && (chan_count == set_n);
  assign set_go     = armed && (trig_sel_hw ? (hw_trig && !hw_blocked) : 1'b1);
  assign last_conv  = (CNT_W'(k) == set_n - CNT_W'(1));
  assign fin_evt    = (state == S_FIN);
  assign coco_set   = fin_evt && acc && (res_count >= set_n);

  assign conv_start = (state == S_START);
  assign res_push   = (state == S_WAIT) && conv_done;
  assign chan_flush = fin_evt && !cont_en && !trig_sel_hw;
  assign chan_idx   = scan_en ? k : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      code_q <= '0;
      k      <= '0;
      acc    <= 1'b0;
      coco   <= 1'b0;
    end else if (cfg_wr) begin
      state  <= S_IDLE;
      code_q <= cfg_code;
      k      <= '0;
      coco   <= 1'b0;
    end else begin
      if (coco_set)             coco <= 1'b1;
      else if (res_count == '0) coco <= 1'b0;
      case (state)
        S_IDLE: if (set_go) begin
          state <= S_START;
          k     <= '0;
          acc   <= hit_seed(cmp_all);
        end
        S_START: state <= S_WAIT;
        S_WAIT: if (conv_done) begin
          acc <= hit_fold(cmp_all, acc, conv_hit);
          if (last_conv) state <= S_FIN;
          else begin
            k     <= k + IDX_W'(1);
            state <= S_START;
          end
        end
        S_FIN: if (cont_en) begin
          state <= S_START;
          k     <= '0;
          acc   <= hit_seed(cmp_all);
        end else begin
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_start_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    set_go |-> (chan_count == set_n));
  a_r7_mask_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (set_go && trig_sel_hw) |-> !hw_blocked);
  a_r9_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && cont_en && !cfg_wr) |=> conv_start);
  a_r3_coco_has_results: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coco) |-> ($past(res_count) >= set_n));
  a_r1_one_start_per_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cfg_wr) |=> (state == S_WAIT));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W  = 5,
  parameter int unsigned RES_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_depth_wr,
  input  logic [2:0]        cfg_depth,
  input  logic              cmp_all,
  input  logic              scan_en,
  input  logic              cont_en,
  input  logic              trig_sel_hw,
  input  logic              trig_mask,
  input  logic              trig_mask_auto,
  input  logic              hw_trig,
  input  logic              ch_wr,
  input  logic [CH_W-1:0]   ch_wdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              conv_hit,
  input  logic              res_rd,
  output logic [RES_W-1:0]  res_data,
  output logic              res_valid
  ,output logic             coco
);
  logic [CNT_W-1:0] chan_count, res_count, set_n;
  logic [IDX_W-1:0] chan_idx;
  logic             res_push, chan_flush, chan_push;

  assign chan_push = ch_wr && !cfg_depth_wr && (chan_count < set_n);
  assign res_valid = (res_count != '0);

  adc_seq_fifo #(.W(CH_W), .D(MAX_DEPTH)) u_chan_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (cfg_depth_wr || chan_flush),
    .push  (chan_push),
    .din   (ch_wdata),
    .pop   (1'b0),
    .idx   (chan_idx),
    .dout  (conv_chan),
    .count (chan_count)
  );

  adc_seq_fifo #(.W(RES_W), .D(MAX_DEPTH)) u_res_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (cfg_depth_wr),
    .push  (res_push),
    .din   (conv_result),
    .pop   (res_rd),
    .idx   ('0),
    .dout  (res_data),
    .count (res_count)
  );

  adc_seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_depth_wr),
    .cfg_code       (cfg_depth),
    .cmp_all        (cmp_all),
    .scan_en        (scan_en),
    .cont_en        (cont_en),
    .trig_sel_hw    (trig_sel_hw),
    .trig_mask      (trig_mask),
    .trig_mask_auto (trig_mask_auto),
    .hw_trig        (hw_trig),
    .chan_count     (chan_count),
    .res_count      (res_count),
    .conv_done      (conv_done),
    .conv_hit       (conv_hit),
    .conv_start     (conv_start),
    .chan_idx       (chan_idx),
    .res_push       (res_push),
    .chan_flush     (chan_flush),
    .coco           (coco),
    .set_n          (set_n)
  );

  a_r12_no_push_past_set: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_count == set_n && !chan_flush && !cfg_depth_wr) |=> (chan_count == $past(chan_count)));
  a_r10_coco_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (coco && !res_valid && !res_push && !cfg_depth_wr) |=> !coco);
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W  = 5;
  localparam int RES_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_depth_wr = 0; logic [2:0] cfg_depth = 0;
  logic cmp_all = 0, scan_en = 0, cont_en = 0, trig_sel_hw = 0;
  logic trig_mask = 0, trig_mask_auto = 0, hw_trig = 0;
  logic ch_wr = 0; logic [CH_W-1:0] ch_wdata = 0;
  logic conv_start; logic [CH_W-1:0] conv_chan;
  logic conv_done = 0; logic [RES_W-1:0] conv_result = 0; logic conv_hit = 0;
  logic res_rd = 0; logic [RES_W-1:0] res_data; logic res_valid, coco;

  int n_chk = 0, n_fail = 0, seed = 1234;
  int nseen = 0, nconv = 0, busy = 0, dly = 0;
  logic [CH_W-1:0] seen_ch [64];
  logic [CH_W-1:0] ch_q [8];
  bit hit_pat [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top #(.CH_W(CH_W), .RES_W(RES_W)) dut (.*);

  function automatic logic [RES_W-1:0] exp_res(input logic [CH_W-1:0] ch, input int k);
    return RES_W'((int'(ch) * 37 + k * 5 + 11) % 4096);
  endfunction

  // converter core model: two idle cycles, then one done strobe
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (busy != 0) begin
      if (dly == 0) begin
        conv_done   = 1'b1;
        conv_result = exp_res(seen_ch[(nseen-1) % 64], nconv);
        conv_hit    = hit_pat[nconv % 8];
        nconv++;
        busy = 0;
      end else dly--;
    end
    if (conv_start && busy == 0 && rst_n) begin
      busy = 1; dly = 2;
      if (nseen < 64) seen_ch[nseen] = conv_chan;
      nseen++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic depth_write(input int code);
    @(negedge clk); cfg_depth = 3'(code); cfg_depth_wr = 1;
    @(negedge clk); cfg_depth_wr = 0;
  endtask

  task automatic wr_ch(input logic [CH_W-1:0] c);
    @(negedge clk); ch_wr = 1; ch_wdata = c;
    @(negedge clk); ch_wr = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); hw_trig = 1;
    @(negedge clk); hw_trig = 0;
  endtask

  task automatic rd_check(input logic [RES_W-1:0] e, input string req);
    @(negedge clk);
    check(res_valid === 1'b1 && res_data === e, req, int'(res_data), int'(e));
    res_rd = 1;
    @(negedge clk); res_rd = 0;
  endtask

  task automatic wait_conv(input int n);
    for (int t = 0; t < 400 && nconv < n; t++) @(negedge clk);
  endtask

  task automatic run_set(input int code, input bit all_mode, input bit scan);
    int n; bit any_h, all_h;
    cmp_all = all_mode; scan_en = scan; cont_en = 0; trig_sel_hw = 0;
    depth_write(code);
    cyc(4);
    nseen = 0; nconv = 0;
    n = (code == 0) ? 1 : code + 1;
    check(res_valid === 1'b0 && coco === 1'b0, "R11 queues empty after depth write", int'(res_valid), 0);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && n > 1) begin
        cyc(6);
        check(nseen == 0, "R2 no start before queue level", nseen, 0);
      end
      wr_ch(ch_q[i]);
    end
    wr_ch(5'd31); // R12 extra write while full
    wait_conv(n);
    cyc(6);
    check(nseen == n, "R1/R12 start count for set size", nseen, n);
    for (int i = 0; i < n; i++) begin
      logic [CH_W-1:0] ec;
      ec = scan ? ch_q[i] : ch_q[0];
      check(seen_ch[i] === ec, "R6 channel order", int'(seen_ch[i]), int'(ec));
    end
    any_h = 0; all_h = 1;
    for (int i = 0; i < n; i++) begin any_h |= hit_pat[i]; all_h &= hit_pat[i]; end
    check(coco === (all_mode ? all_h : any_h), all_mode ? "R5/R3 AND verdict" : "R4/R3 OR verdict",
          int'(coco), int'(all_mode ? all_h : any_h));
    for (int i = 0; i < n; i++) begin
      logic [CH_W-1:0] ec;
      ec = scan ? ch_q[i] : ch_q[0];
      rd_check(exp_res(ec, i), "R10 oldest result first");
    end
    @(negedge clk);
    check(coco === 1'b0 && res_valid === 1'b0, "R10 coco clears when drained", int'(coco), 0);
    cyc(6);
    check(nseen == n, "R12 no extra set from ignored write", nseen, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    bit prevc;
    cyc(3); rst_n = 1; cyc(1);
    check(coco === 1'b0 && res_valid === 1'b0 && conv_start === 1'b0, "R10 reset state", int'(coco), 0);

    // directed: OR with single hit, AND with single miss, scan off, single shot
    ch_q = '{3, 8, 12, 17, 21, 26, 30, 1};
    hit_pat = '{0, 0, 1, 0, 0, 0, 0, 0};
    run_set(3, 0, 1);
    hit_pat = '{1, 1, 0, 1, 1, 1, 1, 1};
    run_set(7, 1, 1);
    hit_pat = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_set(2, 1, 0);
    run_set(0, 0, 1);

    // R7 manual mask, R8 automatic mask, R12 channel kept in hw mode
    depth_write(0); cyc(4);
    nseen = 0; nconv = 0;
    trig_sel_hw = 1; trig_mask = 1; trig_mask_auto = 0; cmp_all = 0; scan_en = 1;
    hit_pat[0] = 1; hit_pat[1] = 1;
    wr_ch(5'd7);
    cyc(3);
    check(nseen == 0, "R7 hw mode waits for trigger", nseen, 0);
    pulse_trig(); cyc(8);
    check(nseen == 0, "R7 masked trigger ignored", nseen, 0);
    trig_mask = 0;
    pulse_trig(); cyc(8);
    check(nseen == 1, "R7 unmasked trigger starts", nseen, 1);
    check(coco === 1'b1, "R3 single conversion completes", int'(coco), 1);
    trig_mask_auto = 1; trig_mask = 0;
    pulse_trig(); cyc(8);
    check(nseen == 1, "R8 auto mask with results pending", nseen, 1);
    rd_check(exp_res(5'd7, 0), "R10 read in hw mode");
    cyc(2);
    pulse_trig(); cyc(8);
    check(nseen == 2, "R8 trigger accepted after drain", nseen, 2);
    rd_check(exp_res(5'd7, 1), "R12 channel kept for next trigger");
    trig_sel_hw = 0; trig_mask_auto = 0;

    // R9 continuous restart
    ch_q[0] = 5'd4; ch_q[1] = 5'd9;
    cmp_all = 1; scan_en = 1; cont_en = 1;
    depth_write(1); cyc(4);
    nseen = 0; nconv = 0;
    wr_ch(ch_q[0]); wr_ch(ch_q[1]);
    prevc = 0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (coco && !prevc) break;
      prevc = coco;
    end
    check(coco === 1'b1 && conv_start === 1'b1, "R9 restart with coco rise", int'(conv_start), 1);
    wait_conv(4);
    check(seen_ch[2] === 5'd4 && seen_ch[3] === 5'd9, "R9 same channel order", int'(seen_ch[3]), 9);
    cont_en = 0;
    depth_write(0);
    check(res_valid === 1'b0 && coco === 1'b0, "R11 flush abandons running set", int'(res_valid), 0);
    cyc(8);

    // constrained random sets
    for (int it = 0; it < 16; it++) begin
      int code; bit am, sc;
      code = $unsigned($random(seed)) % 8;
      am = $random(seed) & 1;
      sc = ($unsigned($random(seed)) % 4) != 0;
      for (int i = 0; i < 8; i++) begin
        ch_q[i] = CH_W'($random(seed) % 31);
        hit_pat[i] = am ? (($unsigned($random(seed)) % 8) != 0) : (($unsigned($random(seed)) % 5) == 0);
      end
      run_set(code, am, sc);
    end
    report();
  end
endmodule